// File: doc/BRIEF.md
# Pipelined Fixed-Point Adaptive-Filter Error Unit

This block is the error path of an N-tap adaptive FIR filter. Each cycle that `in_valid` is high, it shifts a new signed sample into its tap history. It forms the inner product of the tap vector with the weight vector on `w_in`, keeps the upper word of that product as the filter output y, and subtracts y from the desired sample `d_in`. The resulting error leaves through a register, together with a valid flag. A weight-update stage elsewhere in the filter uses this error.

Each multiplication is broken into 2-bit digits of the sample. Every tap produces one partial product per digit: the weight times a value from 0 to 3, or, for the most significant digit, a value from −2 to 1. All partial products with the same digit position are first summed across the taps in one binary adder tree per digit. A single shift-add tree then weights those per-digit sums by 4^k and combines them. The pipeline has only two register stages. One stage sits inside the shift-add tree, after its first adder level. The other holds the error right after the subtraction.

Top module: `lms_err_pipe`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears `e_out` to 0, `e_valid` to 0 and the whole sample history to 0. Samples seen before a reset do not contribute to any product computed after it.
- R2: The tap vector is {x(n), x(n−1), …, x(n−N+1)}, where x(n) is the current `x_in` and the history holds the N−1 samples accepted before it. The history shifts only on cycles with `in_valid` high. `x_in`, `w_in` and `d_in` on other cycles have no effect on any later result.
- R3: `e_valid` is high in exactly the cycle two rising edges after an edge at which `in_valid` was sampled high, and low otherwise.
- R4: y is bits [L+log2N+W−1 : L+log2N] of the exact two's-complement sum Σ w_j·x(n−j). Here w_j is the signed W-bit field `w_in[j*W +: W]`, and x and w are two's-complement integers. This is an arithmetic right shift by L+log2N bits, which truncates toward minus infinity.
- R5: `e_out` = (d − y) mod 2^W. Here d is `d_in`, signed W bits in the same format as y, sampled in the same cycle as the sample.
- R6: Weights and the desired sample are taken only in the `in_valid` cycle. Changing them in the next cycle does not alter the pending result.
- R7: The result is exact over the full signed range, including x = −2^(L−1), x = 2^(L−1)−1 and weights of −2^(W−1) and 2^(W−1)−1. The top sample digit is treated as signed.
- R8: When `e_valid` is low, `e_out` keeps the last error produced (0 after reset).
- R9: `in_valid` may be high on every cycle. Each accepted sample then yields its own result, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A new sample, desired value and weight vector are present |
| x_in | input | XW | Newest input sample, signed |
| w_in | input | N_TAPS*WW | Weight vector, tap j in bits [j*WW +: WW], signed |
| d_in | input | WW | Desired sample, signed, same format as y |
| e_out | output | WW | Registered error d − y |
| e_valid | output | 1 | e_out holds a new error this cycle |

## Verification
The bench builds the block with 8 taps, 8-bit samples and 16-bit weights. That makes four digit positions, three adder levels per digit tree and a two-level shift-add tree, so both the registered and the combinational shift-add levels are in use. Against a behavioural model, it runs back-to-back streams, streams with idle gaps carrying junk inputs, and full-scale signed extremes that exercise the signed top digit. It also checks weight changes right after acceptance and a reset in the middle of a stream.

// File: rtl/lms_err_pkg.sv
// Shared definitions for the adaptive-filter error unit.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lms_err_pkg;

    // Value of one 2-bit slice of an input sample
    typedef enum logic [1:0] {
        DG_ZERO  = 2'd0,
        DG_ONE   = 2'd1,
        DG_TWO   = 2'd2,
        DG_THREE = 2'd3
    } digit_t;

endpackage

// File: rtl/lms_err_ppg.sv
// Partial-product generator for one tap.
// Produces XW/2 partial products wt * digit_k, each WW+2 bits signed.
// Lower digits are unsigned (0..3). The top digit carries the sample sign,
// so its codes 0,1,2,3 mean 0,+1,-2,-1.
// Assumes XW is even and at least 4.
module lms_err_ppg
    import lms_err_pkg::*;
#(
    parameter int WW = 16,
    parameter int XW = 8
) (
    input  logic [WW-1:0]                  wt,
    input  logic [XW-1:0]                  xs,
    output logic [(XW/2)*(WW+2)-1:0]       pp_flat
);
    localparam int PW = WW + 2;
    localparam int D  = XW / 2;

    logic signed [PW-1:0] m1, m2, m3, n1, n2;

    // Multiples of the weight shared by every digit of this tap
    always_comb begin
        m1 = {{2{wt[WW-1]}}, wt};
        m2 = m1 <<< 1;
        m3 = m1 + m2;
        n1 = -m1;
        n2 = -m2;
    end

    for (genvar k = 0; k < D; k++) begin : g_dig
        digit_t dg;
        logic   b0, b1, b2;
        logic signed [PW-1:0] s0, s1, s2;

        assign dg = digit_t'(xs[2*k +: 2]);

        // One-hot decode of the digit value
        always_comb begin
            b0 = (dg == DG_ONE);
            b1 = (dg == DG_TWO);
            b2 = (dg == DG_THREE);
        end

        if (k == D - 1) begin : g_top
            // Signed top digit: +1, -2, -1
            always_comb begin
                s0 = m1;
                s1 = n2;
                s2 = n1;
            end
        end else begin : g_low
            // Unsigned digit: +1, +2, +3
            always_comb begin
                s0 = m1;
                s1 = m2;
                s2 = m3;
            end
        end

        // AND-OR selection of the chosen multiple
        assign pp_flat[k*PW +: PW] = ({PW{b0}} & s0) | ({PW{b1}} & s1) | ({PW{b2}} & s2);
    end

endmodule

// File: rtl/lms_err_addtree.sv
// Combinational binary adder tree over N_IN signed operands.
// Heap layout: leaves at N_IN..2*N_IN-1, node i sums nodes 2i and 2i+1.
// Assumes N_IN is a power of two, at least 2, and OW covers IW + log2(N_IN).
module lms_err_addtree #(
    parameter int N_IN = 8,
    parameter int IW   = 18,
    parameter int OW   = 21
) (
    input  logic [N_IN*IW-1:0] in_flat,
    output logic [OW-1:0]      sum
);
    logic signed [OW-1:0] node [1:2*N_IN-1];

    // Sign-extend each operand into a leaf
    for (genvar i = 0; i < N_IN; i++) begin : g_leaf
        assign node[N_IN+i] = {{(OW-IW){in_flat[i*IW+IW-1]}}, in_flat[i*IW +: IW]};
    end

    // Internal adders, one per heap node
    for (genvar i = 1; i < N_IN; i++) begin : g_add
        assign node[i] = node[2*i] + node[2*i+1];
    end

    assign sum = node[1];

endmodule

// File: rtl/lms_err_shadd.sv
// Shift-add tree combining ND per-digit sums by place value 4^k.
// Node i at heap depth p covers ND>>p digits. Its upper child is shifted
// left by 2*(ND>>(p+1)) bits. The level nearest the leaves is registered,
// which gives one pipeline stage. Levels above it are combinational.
// Assumes ND is a power of two, at least 2. Synchronous active-low reset.
module lms_err_shadd #(
    parameter int ND = 4,
    parameter int IW = 21,
    parameter int OW = 27
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ND*IW-1:0]   in_flat,
    output logic [OW-1:0]      sum
);
    localparam int LOGD     = $clog2(ND);
    localparam int REG_DEPTH = LOGD - 1;

    logic signed [OW-1:0] node [1:2*ND-1];

    // Sign-extend each digit-tree output into a leaf, digit k at ND+k
    for (genvar k = 0; k < ND; k++) begin : g_leaf
        assign node[ND+k] = {{(OW-IW){in_flat[k*IW+IW-1]}}, in_flat[k*IW +: IW]};
    end

    for (genvar i = 1; i < ND; i++) begin : g_node
        localparam int DEP = $clog2(i + 1) - 1;
        localparam int SH  = 2 * (ND >> (DEP + 1));
        logic signed [OW-1:0] cs;

        // Weighted addition of the two children
        assign cs = node[2*i] + (node[2*i+1] <<< SH);

        if (DEP == REG_DEPTH) begin : g_reg
            logic signed [OW-1:0] q;
            // Pipeline cut-set after the first shift-add level
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= cs;
            end
            assign node[i] = q;
        end else begin : g_comb
            assign node[i] = cs;
        end
    end

    assign sum = node[1];

endmodule

// File: rtl/lms_err_pipe.sv
// Error-computation unit of an N-tap adaptive FIR filter.
// Accepts one sample per in_valid cycle into a tap history. It computes
// y = upper WW bits of sum(w_j * x(n-j)) through per-tap digit partial
// products, per-digit adder trees across taps and one shift-add tree,
// then registers e = d - y. Latency is two edges from in_valid to e_valid.
// Assumes N_TAPS is a power of two >= 4 and XW is a power of two >= 4.
// Synchronous active-low reset.
module lms_err_pipe #(
    parameter int N_TAPS = 8,
    parameter int XW     = 8,
    parameter int WW     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [XW-1:0]         x_in,
    input  logic [N_TAPS*WW-1:0]  w_in,
    input  logic [WW-1:0]         d_in,
    output logic [WW-1:0]         e_out,
    output logic                  e_valid
);
    localparam int LOGN = $clog2(N_TAPS);
    localparam int D    = XW / 2;
    localparam int PW   = WW + 2;
    localparam int TW   = PW + LOGN;
    localparam int FW   = WW + XW + LOGN;
    localparam int DROP = XW + LOGN;

    logic [(N_TAPS-1)*XW-1:0] hist;
    logic [N_TAPS*XW-1:0]     taps;
    logic [N_TAPS*D*PW-1:0]   pp_tap_major;
    logic [D*N_TAPS*PW-1:0]   pp_dig_major;
    logic [D*TW-1:0]          tsum;
    logic [FW-1:0]            acc;
    logic                     v1;
    logic [WW-1:0]            d1;
    logic [WW-1:0]            y_w;

    // Sample history: newest accepted sample at the low end
    always_ff @(posedge clk) begin
        if (!rst_n)        hist <= '0;
        else if (in_valid) hist <= {hist[(N_TAPS-2)*XW-1:0], x_in};
    end

    assign taps = {hist, x_in};

    // One partial-product generator per tap
    for (genvar j = 0; j < N_TAPS; j++) begin : g_tap
        lms_err_ppg #(.WW(WW), .XW(XW)) ppg_i (
            .wt      (w_in[j*WW +: WW]),
            .xs      (taps[j*XW +: XW]),
            .pp_flat (pp_tap_major[j*D*PW +: D*PW])
        );
    end

    // Regroup partial products by digit position
    for (genvar k = 0; k < D; k++) begin : g_grp
        for (genvar j = 0; j < N_TAPS; j++) begin : g_t
            assign pp_dig_major[(k*N_TAPS+j)*PW +: PW] = pp_tap_major[(j*D+k)*PW +: PW];
        end
        lms_err_addtree #(.N_IN(N_TAPS), .IW(PW), .OW(TW)) tree_i (
            .in_flat (pp_dig_major[k*N_TAPS*PW +: N_TAPS*PW]),
            .sum     (tsum[k*TW +: TW])
        );
    end

    lms_err_shadd #(.ND(D), .IW(TW), .OW(FW)) shadd_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_flat (tsum),
        .sum     (acc)
    );

    // Valid flag and desired sample travel with the shift-add register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            d1 <= '0;
        end else begin
            v1 <= in_valid;
            d1 <= d_in;
        end
    end

    assign y_w = acc[DROP +: WW];

    // Error register right after the subtraction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_out   <= '0;
            e_valid <= 1'b0;
        end else begin
            e_valid <= v1;
            if (v1) e_out <= d1 - y_w;
        end
    end

endmodule

// File: rtl/lms_err_chk.sv
// Protocol and timing checker for lms_err_pipe, attached by bind.
// Observes ports and the sample history; drives nothing into the design.
module lms_err_chk #(
    parameter int N_TAPS = 8,
    parameter int XW     = 8,
    parameter int WW     = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [XW-1:0]             x_in,
    input logic [(N_TAPS-1)*XW-1:0]  hist,
    input logic [WW-1:0]             e_out,
    input logic                      e_valid
);
    logic [1:0] run_cnt;

    // Cycles since reset release, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= '0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!e_valid && e_out == '0 && hist == '0));

    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> hist[XW-1:0] == $past(x_in));

    p_hist_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(hist));

    p_valid_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd2) |-> (e_valid == $past(in_valid, 2)));

    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd1 && !e_valid) |-> $stable(e_out));

endmodule

bind lms_err_pipe lms_err_chk #(.N_TAPS(N_TAPS), .XW(XW), .WW(WW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .x_in     (x_in),
    .hist     (hist),
    .e_out    (e_out),
    .e_valid  (e_valid)
);

// File: tb/lms_err_pipe_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural model recomputes every error from
// integers and compares e_out and e_valid on every falling edge.
module lms_err_pipe_tb_top;
    localparam int N_TAPS = 8;
    localparam int XW     = 8;
    localparam int WW     = 16;
    localparam int LOGN   = $clog2(N_TAPS);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [XW-1:0]        x_in = '0;
    logic [N_TAPS*WW-1:0] w_in = '0;
    logic [WW-1:0]        d_in = '0;
    logic [WW-1:0]        e_out;
    logic                 e_valid;

    int    errors = 0;
    int    checks = 0;
    bit    chk_on = 1'b0;
    string phase = "R1 reset";

    // Model state
    logic signed [XW-1:0] mh [N_TAPS-1];
    logic                 ev0 = 1'b0, ev1 = 1'b0;
    logic [WW-1:0]        ee0 = '0, last_e = '0;

    lms_err_pipe #(.N_TAPS(N_TAPS), .XW(XW), .WW(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
        .w_in(w_in), .d_in(d_in), .e_out(e_out), .e_valid(e_valid)
    );

    always #2.5 clk = ~clk;

    // Exact dot product, arithmetic shift, subtract, wrap to WW bits
    function automatic logic [WW-1:0] ref_err();
        longint acc = 0;
        longint yv, dv, diff;
        logic [63:0] dbits;
        for (int j = 0; j < N_TAPS; j++) begin
            longint xv, wv;
            xv = (j == 0) ? longint'($signed(x_in)) : longint'(mh[j-1]);
            wv = longint'($signed(w_in[j*WW +: WW]));
            acc += xv * wv;
        end
        yv = acc >>> (XW + LOGN);
        dv = longint'($signed(d_in));
        diff = dv - yv;
        dbits = diff;
        return dbits[WW-1:0];
    endfunction

    // Reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N_TAPS-1; j++) mh[j] <= '0;
            ev0 <= 1'b0; ev1 <= 1'b0; last_e <= '0; ee0 <= '0;
        end else begin
            ev1 <= ev0;
            if (ev0) last_e <= ee0;
            ev0 <= in_valid;
            if (in_valid) begin
                ee0 <= ref_err();
                mh[0] <= $signed(x_in);
                for (int j = 1; j < N_TAPS-1; j++) mh[j] <= mh[j-1];
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            checks++;
            if (e_valid !== ev1) begin
                errors++;
                $display("FAIL R3 (%s) e_valid act=%b exp=%b", phase, e_valid, ev1);
            end
            checks++;
            if (e_out !== last_e) begin
                errors++;
                $display("FAIL %s R5 e_out act=%h exp=%h", phase, e_out, last_e);
            end
        end
    end

    task automatic drive(input bit v, input logic [XW-1:0] x,
                         input logic [WW-1:0] d, input logic [N_TAPS*WW-1:0] w);
        @(negedge clk);
        in_valid = v; x_in = x; d_in = d; w_in = w;
    endtask

    function automatic logic [N_TAPS*WW-1:0] rand_w();
        logic [N_TAPS*WW-1:0] r;
        for (int j = 0; j < N_TAPS; j++) r[j*WW +: WW] = WW'($urandom);
        return r;
    endfunction

    function automatic logic [N_TAPS*WW-1:0] pick_w();
        logic [N_TAPS*WW-1:0] r;
        for (int j = 0; j < N_TAPS; j++) begin
            case ($urandom % 4)
                0: r[j*WW +: WW] = {1'b1, {(WW-1){1'b0}}};
                1: r[j*WW +: WW] = {1'b0, {(WW-1){1'b1}}};
                2: r[j*WW +: WW] = '1;
                default: r[j*WW +: WW] = WW'($urandom);
            endcase
        end
        return r;
    endfunction

    function automatic logic [XW-1:0] pick_x();
        case ($urandom % 5)
            0: return {1'b1, {(XW-1){1'b0}}};
            1: return {1'b0, {(XW-1){1'b1}}};
            2: return '1;
            3: return '0;
            default: return XW'($urandom);
        endcase
    endfunction

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared while in reset
        checks++;
        if (e_out !== '0 || e_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs act=%h/%b exp=0/0", e_out, e_valid);
        end
        rst_n = 1'b1;
        chk_on = 1'b1;

        phase = "R9 R4 back-to-back";
        for (int i = 0; i < 40; i++) drive(1'b1, XW'($urandom), WW'($urandom), rand_w());

        phase = "R2 gaps with junk";
        for (int i = 0; i < 40; i++) begin
            drive(1'b1, XW'($urandom), WW'($urandom), rand_w());
            for (int g = 0; g < int'($urandom % 4); g++)
                drive(1'b0, XW'($urandom), WW'($urandom), rand_w());
        end

        phase = "R7 signed extremes";
        for (int i = 0; i < 40; i++) drive(1'b1, pick_x(), WW'($urandom), pick_w());

        phase = "R6 late weight change";
        for (int i = 0; i < 20; i++) begin
            drive(1'b1, XW'($urandom), WW'($urandom), rand_w());
            drive(1'b0, XW'($urandom), WW'($urandom), rand_w());
        end

        phase = "R8 idle hold";
        for (int i = 0; i < 6; i++) drive(1'b0, XW'($urandom), WW'($urandom), rand_w());

        phase = "R1 mid-stream reset";
        for (int i = 0; i < 5; i++) drive(1'b1, XW'($urandom), WW'($urandom), rand_w());
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) drive(1'b1, XW'($urandom), WW'($urandom), rand_w());

        phase = "R8 drain";
        for (int i = 0; i < 6; i++) drive(1'b0, '0, '0, '0);
        finish_run();
    end

endmodule